// File: doc/BRIEF.md
# Eight-Bit GPIO Port Register Block

This block is the register set behind one 8-bit general-purpose I/O port. A small bus interface writes and reads three registers: an output latch, a direction register and a pull-up control register. From these the block drives a value, an output enable and a pull-up enable for each pin toward the pad ring. It also samples the pin levels through a synchronizer so that software can read them.

A read of the latch address builds each bit separately. A bit whose pin is an output returns the stored latch bit. A bit whose pin is an input returns the synchronized pin level. Bit position 3 is reserved: it has no pin, it reads as 1 in the latch and pull-up registers, and writes to it are ignored. A pull-up turns on only when its control bit is set and the pin is an input.

Top module: `gpio_port_regs`

## Requirements
- R1: While `rst` is high, and after it is released, the latch, direction and pull-up registers hold 0. A read at address 0 or address 2 then returns 8'h08, and `pin_out`, `pin_oe` and `pin_pu` are all 0.
- R2: A write at address 0 stores `bus_wdata` in the latch at the next rising edge. From then on `pin_out` equals the written value with bit 3 cleared.
- R3: A read at address 0 returns the pin level on each input pin (direction bit 0), whatever the latch holds. A change on `pin_in` shows in the read only after the second rising edge that follows the change.
- R4: A read at address 0 returns the latch bit on positions whose direction bit is 1 and the synchronized pin level on positions whose direction bit is 0. The two kinds of position can be mixed freely within one read.
- R5: Bit 3 reads as 1 at addresses 0 and 2. Writes to bit 3 are ignored. `pin_out[3]`, `pin_oe[3]` and `pin_pu[3]` are always 0.
- R6: `pin_pu[i]` is 1 exactly when pull-up bit i is 1 and direction bit i is 0. Address 2 reads back the stored pull-up bits.
- R7: A write at address 1 sets the direction register. `pin_oe` equals the written value with bit 3 cleared. A read at address 1 returns 8'hFF.
- R8: Address 3 maps to no register. A read there returns 8'hFF, and a write there changes no register and no output.
- R9: While `bus_we` is low, no register and no pin output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 direction, 2 pull-up, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pin levels from the pads (asynchronous) |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |
| pin_pu | output | 8 | Pull-up enable per pin |

## Verification
The read path is tried in three ways. First, every pin is an output, which shows that the latch is returned. Second, every pin is an input while the latch holds a value that differs from the pins, which shows that the pin level is returned and not the latch. Third, the nibbles are split both ways between input and output, which exposes a selection that picks the source per register rather than per bit. The pin level is checked one edge after it changes and again two edges after, which fixes the synchronizer depth. Pull-ups are checked with all-input, all-output and mixed directions, and the reserved bit and the unused address are checked with writes of all ones.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_PULL  = 2'd2,
    SEL_NONE  = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int           W         = 8,
  parameter logic [W-1:0] HOLE_MASK = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pull_q
);
  localparam logic [W-1:0] LIVE = ~HOLE_MASK;

  gpio_sel_e sel;
  logic      wr_latch, wr_dir, wr_pull;

  always_comb begin
    sel      = gpio_sel_e'(addr);
    wr_latch = we && (sel == SEL_LATCH);
    wr_dir   = we && (sel == SEL_DIR);
    wr_pull  = we && (sel == SEL_PULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
    end else begin
      if (wr_latch) latch_q <= wdata & LIVE;
      if (wr_dir)   dir_q   <= wdata & LIVE;
      if (wr_pull)  pull_q  <= wdata & LIVE;
    end
  end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int           W         = 8,
  parameter logic [W-1:0] HOLE_MASK = 8'h08
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      latch_q,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      pull_q,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] port_view;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      if (HOLE_MASK[b]) begin : g_hole
        assign port_view[b] = 1'b1;
      end else begin : g_live
        assign port_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
      end
    end
  endgenerate

  always_comb begin
    unique case (gpio_sel_e'(addr))
      SEL_LATCH: rdata = port_view;
      SEL_PULL:  rdata = pull_q | HOLE_MASK;
      default:   rdata = '1;
    endcase
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int           W           = 8,
  parameter int           SYNC_STAGES = 2,
  parameter logic [W-1:0] HOLE_MASK   = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_pu
);
  logic [W-1:0] latch_q, dir_q, pull_q, pin_sync;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_regs #(.W(W), .HOLE_MASK(HOLE_MASK)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
  );

  gpio_rdmux #(.W(W), .HOLE_MASK(HOLE_MASK)) u_rdmux (
    .addr(bus_addr), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
    .pin_sync(pin_sync), .rdata(bus_rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
  assign pin_pu  = pull_q & ~dir_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int           W         = 8,
  parameter logic [W-1:0] HOLE_MASK = 8'h08
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   bus_addr,
  input logic         bus_we,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_pu
);
  // R1: reset clears every pin-side output
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && pin_pu == '0));

  // R2: latch write reaches pin_out
  a_r2_latch_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd0) |=> pin_out == ($past(bus_wdata) & ~HOLE_MASK));

  // R4: output positions read back from the driven value
  a_r4_output_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 2'd0) |-> ((bus_rdata & pin_oe) == (pin_out & pin_oe)));

  // R5: the reserved position reads as one
  a_r5_hole_reads_one: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 2'd0 || bus_addr == 2'd2) |-> ((bus_rdata & HOLE_MASK) == HOLE_MASK));

  // R5: the reserved position drives nothing
  a_r5_hole_quiet: assert property (@(posedge clk) disable iff (rst)
    ((pin_out | pin_oe | pin_pu) & HOLE_MASK) == '0);

  // R6: pull-up never on an output pin
  a_r6_pull_inputs_only: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & pin_oe) == '0);

  // R7: direction write reaches pin_oe
  a_r7_dir_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd1) |=> pin_oe == ($past(bus_wdata) & ~HOLE_MASK));

  // R7, R8: direction and unused addresses read all ones
  a_r8_ones_read: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 2'd1 || bus_addr == 2'd3) |-> bus_rdata == '1);

  // R9: no write, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pu)));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.W(W), .HOLE_MASK(HOLE_MASK)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe, pin_pu;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef enum int {K_RD, K_OUT, K_OE, K_PU} kind_e;
  typedef struct {
    kind_e      kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  gpio_port_regs u_gpio_port_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  // monitor: compares queued expectations 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = bus_rdata;
          K_OUT:   act = pin_out;
          K_OE:    act = pin_oe;
          default: act = pin_pu;
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic chk(input kind_e k, input logic [7:0] e, input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    q.push_back(it);
    step();
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    bus_addr = a;
    chk(K_RD, e, tag);
  endtask

  task automatic reset_checks(input string tag);
    chk_rd(2'd0, 8'h08, tag);
    chk_rd(2'd2, 8'h08, tag);
    chk(K_OUT, 8'h00, tag);
    chk(K_OE,  8'h00, tag);
    chk(K_PU,  8'h00, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    step();
    reset_checks("R1 reset state");

    // R7 direction register
    wr(2'd1, 8'hFF);
    chk(K_OE, 8'hF7, "R7 oe after dir write");
    chk_rd(2'd1, 8'hFF, "R7 dir reads ones");

    // R2 latch on output pins
    wr(2'd0, 8'hA5);
    chk(K_OUT, 8'hA5, "R2 pin_out");
    chk_rd(2'd0, 8'hAD, "R2 latch readback");
    wr(2'd0, 8'h5A);
    chk(K_OUT, 8'h52, "R5 hole write ignored on pin_out");
    chk_rd(2'd0, 8'h5A, "R2 latch readback 2");

    // R9 no strobe, no change
    bus_addr = 2'd0; bus_wdata = 8'hFF;
    chk(K_OUT, 8'h52, "R9 no write without strobe");
    bus_addr = 2'd1;
    chk(K_OE, 8'hF7, "R9 dir unchanged");

    // R3 all inputs read pin level, two-edge delay
    wr(2'd1, 8'h00);
    bus_addr = 2'd0; pin_in = 8'hC3;
    chk(K_RD, 8'h08, "R3 one edge after change");
    chk(K_RD, 8'hCB, "R3 two edges after change");
    chk(K_OUT, 8'h52, "R3 latch still driven");
    pin_in = 8'h3C;
    chk(K_RD, 8'hCB, "R3 second pattern one edge");
    chk(K_RD, 8'h3C, "R3 second pattern two edges");

    // R4 mixed directions
    wr(2'd1, 8'hF0);
    chk(K_OE, 8'hF0, "R7 oe F0");
    chk_rd(2'd0, 8'h5C, "R4 upper out lower in");
    wr(2'd1, 8'h0F);
    chk(K_OE, 8'h07, "R7 oe 07");
    chk_rd(2'd0, 8'h3A, "R4 upper in lower out");

    // R6 pull-ups
    wr(2'd2, 8'hFF);
    chk_rd(2'd2, 8'hFF, "R6 pull readback");
    chk(K_PU, 8'hF0, "R6 pull mixed dir");
    wr(2'd1, 8'h00);
    chk(K_PU, 8'hF7, "R6 pull all inputs");
    wr(2'd1, 8'hFF);
    chk(K_PU, 8'h00, "R6 pull all outputs");
    wr(2'd2, 8'h00);
    chk_rd(2'd2, 8'h08, "R6 pull cleared");

    // R8 unused address
    wr(2'd3, 8'hFF);
    chk_rd(2'd3, 8'hFF, "R8 unused reads ones");
    chk_rd(2'd0, 8'h5A, "R8 latch untouched");
    chk_rd(2'd2, 8'h08, "R8 pull untouched");
    chk(K_OE, 8'hF7, "R8 dir untouched");

    // R5 reserved bit in pull register
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h08);
    chk_rd(2'd2, 8'h08, "R5 pull hole write ignored");
    chk(K_PU, 8'h00, "R5 pull hole no enable");
    wr(2'd2, 8'hF7);
    chk_rd(2'd2, 8'hFF, "R5 pull hole reads one");

    // R1 reset mid-run
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    pin_in = 8'h00;
    step(); step(); step();
    reset_checks("R1 reset after use");

    step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule